// File: doc/BRIEF.md
# Event-Select Performance Monitor Unit

This block counts hardware events for profiling. It holds one free-running cycle counter and four 32-bit event counters. Each event counter follows one line of a bank of single-cycle event strobes, and an 8-bit code picks that line. Software sets the unit up through a plain synchronous register bus. It chooses the code of each counter, starts or stops all counting with one global run bit, and clears the counters with self-clearing strobe bits. It can also slow the cycle counter down through a divide-by-64 prescaler.

Every counter can be read and written. To take a sample, software loads a counter with the two's-complement negative of the wanted count. The counter then wraps after exactly that many events. A wrap sets a sticky overflow flag. The overflow flags and the interrupt enables share one bit layout, and the single interrupt line is high while any flag is set together with its enable. The register bus is a control path with no back-pressure. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Read data is a combinational function of `bus_addr`, so it is available in the same cycle.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset the registers hold these values: control is 0, the event-select register is 0xFFFFFFFF (every counter parked), interrupt enable is 0, the overflow flags are 0, and all counters are 0. `irq` is low.
- R2: Control bit 0 is the one run bit for the whole unit. While it is 0, neither the cycle counter nor any event counter advances.
- R3: Counter i takes its code from event-select bits [8i+7:8i]. While running, code c adds one for every cycle in which `ev_strobe[c]` is high. A code at or above NUM_EVENTS (16 by default) counts nothing.
- R4: Code 0xFF parks a counter. The counter keeps its value and never increments, even while the run bit is set.
- R5: Writing 1 to control bit 1 clears all event counters. Writing 1 to control bit 2 clears the cycle counter and its prescaler. Both bits read back as 0.
- R6: While running, the cycle counter adds one on every clock. When control bit 3 is set, it adds one on every 64th clock instead, counted from the last cycle-counter clear.
- R7: A counter that wraps from 0xFFFFFFFF to 0 sets its overflow flag. The flag layout is bit 0 for the cycle counter and bits 1 to 4 for event counters 0 to 3. The interrupt-enable register uses the same layout.
- R8: Overflow flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly while some overflow flag and its matching enable bit are both 1.
- R10: A bus write to a counter sets its value on that edge. The write takes priority over an event or a tick in the same cycle, and that increment is dropped. Loading -N makes the counter wrap after N events.
- R11: The word address map is: 0 control, 1 cycle counter, 2 interrupt enable, 3 overflow flags, 4 event select, and 5 to 8 event counters 0 to 3. Control bits 0 and 3 read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ev_strobe | input | 16 | Single-cycle event strobes, one per event code |
| irq | output | 1 | Interrupt request |
| ovf_flags | output | 5 | Current overflow flags, same layout as the register |

## Verification
Read data depends only on the address, so the bench samples a register value shortly after a falling edge, in the same cycle it sets the address. A write, a clear strobe or an event strobe is driven at one falling edge and is captured by the next rising edge. Its result, including a set overflow flag and the resulting `irq` level, is checked at the following falling edge. Cycle-counter checks count the rising edges since the clearing write: 10 edges give 10 without the divider, and with the divider the value is 2 after 191 edges and 3 after 192.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int PMU_CNT_W   = 32;
  localparam int PMU_NUM_CTR = 4;
  localparam int PMU_CODE_W  = 8;

  // Word addresses on the register bus
  localparam int ADR_CTRL = 0;
  localparam int ADR_CYC  = 1;
  localparam int ADR_IEN  = 2;
  localparam int ADR_OVF  = 3;
  localparam int ADR_SEL  = 4;
  localparam int ADR_CTR0 = 5;

  // Control bit positions
  localparam int CTL_RUN   = 0;
  localparam int CTL_EVRST = 1;
  localparam int CTL_CYRST = 2;
  localparam int CTL_DIV   = 3;

  localparam logic [PMU_CODE_W-1:0] CODE_PARK = '1;
endpackage

// File: rtl/pmu_event_counter.sv
module pmu_event_counter import pmu_pkg::*; #(
  parameter int CNT_W      = PMU_CNT_W,
  parameter int CODE_W     = PMU_CODE_W,
  parameter int NUM_EVENTS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic [CODE_W-1:0]     code,
  input  logic [NUM_EVENTS-1:0] events,
  input  logic                  wr_en,
  input  logic [CNT_W-1:0]      wr_data,
  input  logic                  clr,
  output logic [CNT_W-1:0]      count,
  output logic                  wrap
);
  localparam int EXT = 1 << CODE_W;

  logic [EXT-1:0] ev_ext;
  logic           hit;
  logic           step;

  // Codes beyond the implemented events see a zero line
  assign ev_ext = EXT'(events);
  assign hit    = (code != CODE_PARK) && ev_ext[code];
  assign step   = run && hit && !wr_en && !clr;
  assign wrap   = step && (count == '1);

  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (wr_en) count <= wr_data;
    else if (clr)   count <= '0;
    else if (step)  count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter import pmu_pkg::*; #(
  parameter int CNT_W     = PMU_CNT_W,
  parameter int DIV_RATIO = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             div_sel,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic tick;
  logic step;

  generate
    if (DIV_RATIO > 1) begin : g_div
      localparam int PW = $clog2(DIV_RATIO);
      logic [PW-1:0] presc_q;
      logic          last;
      assign last = (presc_q == PW'(DIV_RATIO - 1));
      always_ff @(posedge clk) begin
        if (rst || clr)          presc_q <= '0;
        else if (run && div_sel) presc_q <= last ? '0 : presc_q + PW'(1);
      end
      assign tick = div_sel ? last : 1'b1;
    end else begin : g_nodiv
      logic unused_div;
      assign unused_div = div_sel;
      assign tick = 1'b1;
    end
  endgenerate

  assign step = run && tick && !wr_en && !clr;
  assign wrap = step && (count == '1);

  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (wr_en) count <= wr_data;
    else if (clr)   count <= '0;
    else if (step)  count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/pmu_flag_bank.sv
module pmu_flag_bank #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] ien,
  output logic [W-1:0] flags,
  output logic         irq
);
  logic [W-1:0] clr_bits;

  assign clr_bits = clr_wr ? clr_mask : '0;

  // A wrap in the same cycle as a clear keeps the flag set
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_bits) | set;
  end

  assign irq = |(flags & ien);
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit import pmu_pkg::*; #(
  parameter int CNT_W      = PMU_CNT_W,
  parameter int NUM_CTR    = PMU_NUM_CTR,
  parameter int CODE_W     = PMU_CODE_W,
  parameter int NUM_EVENTS = 16,
  parameter int DIV_RATIO  = 64,
  parameter int ADDR_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [CNT_W-1:0]      bus_wdata,
  output logic [CNT_W-1:0]      bus_rdata,
  input  logic [NUM_EVENTS-1:0] ev_strobe,
  output logic                  irq,
  output logic [NUM_CTR:0]      ovf_flags
);
  localparam int FLAG_W = NUM_CTR + 1;
  localparam int SEL_W  = NUM_CTR * CODE_W;

  logic                          wr;
  logic                          en_q;
  logic                          div_q;
  logic [SEL_W-1:0]              evsel_q;
  logic [FLAG_W-1:0]             ien_q;
  logic                          ev_clr;
  logic                          cyc_clr;
  logic [CNT_W-1:0]              cyc_cnt;
  logic                          cyc_wrap;
  logic [NUM_CTR-1:0][CNT_W-1:0] ctr_cnt;
  logic [NUM_CTR-1:0]            ctr_wrap;

  assign wr      = bus_sel && bus_wr;
  assign ev_clr  = wr && (bus_addr == ADDR_W'(ADR_CTRL)) && bus_wdata[CTL_EVRST];
  assign cyc_clr = wr && (bus_addr == ADDR_W'(ADR_CTRL)) && bus_wdata[CTL_CYRST];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      div_q   <= 1'b0;
      evsel_q <= '1;
      ien_q   <= '0;
    end else if (wr) begin
      if (bus_addr == ADDR_W'(ADR_CTRL)) begin
        en_q  <= bus_wdata[CTL_RUN];
        div_q <= bus_wdata[CTL_DIV];
      end
      if (bus_addr == ADDR_W'(ADR_SEL)) evsel_q <= bus_wdata[SEL_W-1:0];
      if (bus_addr == ADDR_W'(ADR_IEN)) ien_q   <= bus_wdata[FLAG_W-1:0];
    end
  end

  pmu_cycle_counter #(.CNT_W(CNT_W), .DIV_RATIO(DIV_RATIO)) u_cyc (
    .clk     (clk),
    .rst     (rst),
    .run     (en_q),
    .div_sel (div_q),
    .wr_en   (wr && (bus_addr == ADDR_W'(ADR_CYC))),
    .wr_data (bus_wdata),
    .clr     (cyc_clr),
    .count   (cyc_cnt),
    .wrap    (cyc_wrap)
  );

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      pmu_event_counter #(.CNT_W(CNT_W), .CODE_W(CODE_W), .NUM_EVENTS(NUM_EVENTS)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .run     (en_q),
        .code    (evsel_q[i*CODE_W +: CODE_W]),
        .events  (ev_strobe),
        .wr_en   (wr && (bus_addr == ADDR_W'(ADR_CTR0 + i))),
        .wr_data (bus_wdata),
        .clr     (ev_clr),
        .count   (ctr_cnt[i]),
        .wrap    (ctr_wrap[i])
      );
    end
  endgenerate

  pmu_flag_bank #(.W(FLAG_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set      ({ctr_wrap, cyc_wrap}),
    .clr_wr   (wr && (bus_addr == ADDR_W'(ADR_OVF))),
    .clr_mask (bus_wdata[FLAG_W-1:0]),
    .ien      (ien_q),
    .flags    (ovf_flags),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(ADR_CTRL): begin
        bus_rdata[CTL_RUN] = en_q;
        bus_rdata[CTL_DIV] = div_q;
      end
      ADDR_W'(ADR_CYC): bus_rdata = cyc_cnt;
      ADDR_W'(ADR_IEN): bus_rdata = CNT_W'(ien_q);
      ADDR_W'(ADR_OVF): bus_rdata = CNT_W'(ovf_flags);
      ADDR_W'(ADR_SEL): bus_rdata = CNT_W'(evsel_q);
      default: begin
        for (int i = 0; i < NUM_CTR; i++)
          if (bus_addr == ADDR_W'(ADR_CTR0 + i)) bus_rdata = ctr_cnt[i];
      end
    endcase
  end
endmodule

// File: rtl/perf_mon_chk.sv
module perf_mon_chk import pmu_pkg::*; #(
  parameter int CNT_W   = PMU_CNT_W,
  parameter int NUM_CTR = PMU_NUM_CTR,
  parameter int CODE_W  = PMU_CODE_W,
  parameter int ADDR_W  = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_sel,
  input logic                          bus_wr,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [CNT_W-1:0]              bus_wdata,
  input logic                          irq,
  input logic [NUM_CTR:0]              ovf_flags,
  input logic                          en_q,
  input logic                          div_q,
  input logic [NUM_CTR*CODE_W-1:0]     evsel_q,
  input logic [CNT_W-1:0]              cyc_cnt,
  input logic [NUM_CTR-1:0][CNT_W-1:0] ctr_cnt
);
  logic             wr;
  logic             ctl_wr;
  logic             cyc_touch;
  logic             ev_rst;
  logic [NUM_CTR:0] keep;

  assign wr        = bus_sel && bus_wr;
  assign ctl_wr    = wr && (bus_addr == ADDR_W'(ADR_CTRL));
  assign ev_rst    = ctl_wr && bus_wdata[CTL_EVRST];
  assign cyc_touch = (wr && (bus_addr == ADDR_W'(ADR_CYC))) || (ctl_wr && bus_wdata[CTL_CYRST]);
  assign keep      = (wr && (bus_addr == ADDR_W'(ADR_OVF))) ? ~bus_wdata[NUM_CTR:0] : '1;

  AST_IDLE_CYC: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !cyc_touch) |=> $stable(cyc_cnt)) else $error("idle cycle counter moved"); // R2

  AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
    (en_q && !div_q && !cyc_touch) |=> (cyc_cnt == $past(cyc_cnt) + CNT_W'(1))) else $error("cycle step"); // R6

  AST_EV_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ev_rst |=> (ctr_cnt == '0)) else $error("event reset"); // R5

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr && (bus_addr == ADDR_W'(ADR_CTR0))) |=> (ctr_cnt[0] == $past(bus_wdata))) else $error("write priority"); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ovf_flags & $past(ovf_flags & keep)) == $past(ovf_flags & keep))) else $error("flag lost"); // R8

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ovf_flags == '0) |-> !irq) else $error("irq without flag"); // R9

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_park
      AST_PARK_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((evsel_q[i*CODE_W +: CODE_W] == CODE_PARK) && !ev_rst &&
         !(wr && (bus_addr == ADDR_W'(ADR_CTR0 + i)))) |=> $stable(ctr_cnt[i]))
        else $error("parked counter moved"); // R4
    end
  endgenerate
endmodule

bind perf_mon_unit perf_mon_chk u_perf_mon_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .ovf_flags (ovf_flags),
  .en_q      (en_q),
  .div_q     (div_q),
  .evsel_q   (evsel_q),
  .cyc_cnt   (cyc_cnt),
  .ctr_cnt   (ctr_cnt)
);

// File: tb/test_perf_mon_unit.sv
module test_perf_mon_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] ev_strobe;
  logic        irq;
  logic [4:0]  ovf_flags;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [3:0] A_CTRL = 4'd0, A_CYC = 4'd1, A_IEN = 4'd2, A_OVF = 4'd3,
                         A_SEL = 4'd4, A_C0 = 4'd5, A_C1 = 4'd6, A_C2 = 4'd7, A_C3 = 4'd8;

  always #2 clk = ~clk;  // 250 MHz

  perf_mon_unit i_perf_mon_unit (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_strobe(ev_strobe),
    .irq(irq), .ovf_flags(ovf_flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic read_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ev_strobe[idx] = 1'b1;
      @(negedge clk);
      ev_strobe = '0;
    end
  endtask

  task automatic t_reset;
    read_chk("R1 ctrl", A_CTRL, 32'h0);
    read_chk("R1 sel", A_SEL, 32'hFFFF_FFFF);
    read_chk("R1 ien", A_IEN, 32'h0);
    read_chk("R1 ovf", A_OVF, 32'h0);
    read_chk("R1 ctr0", A_C0, 32'h0);
    read_chk("R1 ctr3", A_C3, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    repeat (5) @(negedge clk);
    read_chk("R2 cyc idle after reset", A_CYC, 32'h0);
  endtask

  task automatic t_parked;
    bus_write(A_CTRL, 32'h1);
    for (int e = 0; e < 16; e++) pulse(e, 1);
    read_chk("R4 parked ctr0", A_C0, 32'h0);
    read_chk("R4 parked ctr2", A_C2, 32'h0);
  endtask

  task automatic t_select;
    bus_write(A_SEL, 32'h3000_0B07);
    read_chk("R11 sel readback", A_SEL, 32'h3000_0B07);
    pulse(7, 3);
    pulse(11, 2);
    pulse(0, 1);
    pulse(3, 2);
    read_chk("R3 ctr0 code 07", A_C0, 32'd3);
    read_chk("R3 ctr1 code 0B", A_C1, 32'd2);
    read_chk("R3 ctr2 code 00", A_C2, 32'd1);
    read_chk("R3 ctr3 code 30 unimplemented", A_C3, 32'd0);
  endtask

  task automatic t_disable;
    logic [31:0] a, b;
    bus_write(A_CTRL, 32'h0);
    pulse(7, 2);
    read_chk("R2 ctr0 stopped", A_C0, 32'd3);
    bus_read(A_CYC, a);
    repeat (5) @(negedge clk);
    bus_read(A_CYC, b);
    chk("R2 cyc stopped", b, a);
  endtask

  task automatic t_cycle;
    bus_write(A_CTRL, 32'h5);
    read_chk("R5 cyc cleared", A_CYC, 32'd0);
    read_chk("R5 R11 ctrl readback", A_CTRL, 32'h1);
    repeat (10) @(negedge clk);
    read_chk("R6 cyc per clock", A_CYC, 32'd10);
  endtask

  task automatic t_divider;
    bus_write(A_CTRL, 32'hD);
    read_chk("R11 ctrl div readback", A_CTRL, 32'h9);
    read_chk("R5 cyc cleared div", A_CYC, 32'd0);
    repeat (191) @(negedge clk);
    read_chk("R6 div after 191", A_CYC, 32'd2);
    @(negedge clk);
    read_chk("R6 div after 192", A_CYC, 32'd3);
  endtask

  task automatic t_evreset;
    bus_write(A_CTRL, 32'h3);
    read_chk("R5 ctr0 reset", A_C0, 32'd0);
    read_chk("R5 ctr1 reset", A_C1, 32'd0);
    read_chk("R5 ctr2 reset", A_C2, 32'd0);
    read_chk("R5 ctrl bit1 reads 0", A_CTRL, 32'h1);
  endtask

  task automatic t_overflow;
    bus_write(A_C0, 32'hFFFF_FFFD);
    bus_write(A_IEN, 32'h02);
    pulse(7, 2);
    read_chk("R10 ctr0 before wrap", A_C0, 32'hFFFF_FFFF);
    read_chk("R7 no flag yet", A_OVF, 32'h0);
    chk("R9 irq low", {31'h0, irq}, 32'h0);
    pulse(7, 1);
    read_chk("R10 ctr0 wrapped", A_C0, 32'h0);
    read_chk("R7 flag bit1", A_OVF, 32'h02);
    chk("R9 irq high", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_w1c;
    bus_write(A_OVF, 32'h00);
    read_chk("R8 write 0 keeps", A_OVF, 32'h02);
    bus_write(A_OVF, 32'h1D);
    read_chk("R8 other bits keep", A_OVF, 32'h02);
    bus_write(A_OVF, 32'h02);
    read_chk("R8 write 1 clears", A_OVF, 32'h0);
    chk("R9 irq cleared", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_clkwrap;
    bus_write(A_CYC, 32'hFFFF_FFFE);
    read_chk("R10 cyc written", A_CYC, 32'hFFFF_FFFE);
    @(negedge clk);
    @(negedge clk);
    read_chk("R7 cyc wrapped", A_CYC, 32'h0);
    chk("R7 flag bit0", {27'h0, ovf_flags}, 32'h01);
    chk("R9 masked irq", {31'h0, irq}, 32'h0);
    bus_write(A_IEN, 32'h01);
    chk("R9 unmasked irq", {31'h0, irq}, 32'h1);
    bus_write(A_OVF, 32'h01);
    chk("R8 clock flag cleared", {27'h0, ovf_flags}, 32'h0);
  endtask

  task automatic t_write_prio;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_C0; bus_wdata = 32'd100;
    ev_strobe[7] = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; ev_strobe = '0;
    read_chk("R10 write beats event", A_C0, 32'd100);
    pulse(7, 1);
    read_chk("R10 counts after write", A_C0, 32'd101);
  endtask

  task automatic t_park_live;
    bus_write(A_SEL, 32'h3000_0BFF);
    pulse(7, 2);
    pulse(11, 1);
    read_chk("R4 parked while running", A_C0, 32'd101);
    read_chk("R3 neighbour counts", A_C1, 32'd1);
  endtask

  initial begin
    rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; ev_strobe = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_parked();
    t_select();
    t_disable();
    t_cycle();
    t_divider();
    t_evreset();
    t_overflow();
    t_w1c();
    t_clkwrap();
    t_write_prio();
    t_park_live();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule